// File: doc/BRIEF.md
# Differential-Coefficient FIR Filter

This block is a sequential finite impulse response filter of `NTAP` taps with one shared multiplier. It keeps the filter as a raw first coefficient plus the first-order differences between neighbouring coefficients. It also keeps a store of the per-tap product terms from the previous output. Every tap term but the first is rebuilt for the next output by adding `difference × sample` to the neighbour's stored term. The tap-0 term always takes a full multiply. Any tap whose difference is zero costs no multiply and no cycle: its term comes across from the store untouched.

Coefficients enter as raw values through a small stream port. The block forms the differences itself. A load restarts the filter with an all-zero history. For the first `NTAP` outputs after reset or after a load, the block works in direct form and walks every tap with a running coefficient. Once the store is full, it switches to the difference scheme. Samples enter and results leave through valid/ready streams. The block takes a sample only while it is idle. It then keeps `in_ready` low until its result has been taken, so `out_valid` back-pressure stalls the input.

Top module: `fir_diffcoef`

## Requirements
- R1: Each result equals the signed convolution of the last `NTAP` samples with the loaded coefficients, sum of c[k]·x[j−k]. Samples older than the last reset or load count as zero.
- R2: A coefficient beat with `cfg_first` high writes coefficient 0. The beats that follow write coefficients 1, 2, … in order. Beats after the `NTAP`-th are ignored. A beat with `cfg_first` clears the sample history and the product store.
- R3: For the first `NTAP` results after reset or a load, `out_valid` rises exactly `NTAP` clock edges after the edge that accepted the sample.
- R4: For every later result, that latency is 1 plus the number of nonzero differences c[k]−c[k−1], for k = 1…`NTAP`−1.
- R5: A tap with a zero difference takes no multiplier cycle. With all coefficients equal, the steady-state latency is 1 and the result is still exact.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds. `in_ready` is low from the accepting edge until the result is taken.
- R7: After reset, `out_valid` is low, `in_ready` and `cfg_ready` are high, and all coefficients are zero, so results are zero.
- R8: Extreme operands, such as −2^(DW−1) samples and full-range coefficients with differences of magnitude near 2^CW, give exact results with no wrap.
- R9: `cfg_ready` is high only while the block is idle. A `cfg_valid` beat takes priority over a sample, and `in_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Coefficient beat valid |
| cfg_ready | output | 1 | Coefficient beat can be taken (idle) |
| cfg_first | input | 1 | Beat carries coefficient 0 and starts a load |
| cfg_coef | input | CW | Raw signed coefficient |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample can be taken |
| in_data | input | DW | Signed sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_data | output | CW+DW+clog2(NTAP) | Signed filter result |

## Verification
On every cycle, the assertions check the output hold under back-pressure and that no sample is taken while a result waits. They check that the difference walk lands only on taps with a nonzero difference, and that the direct-form walk visits taps in order within a bound of `NTAP` cycles. They also check the history shift and that surplus coefficient beats leave the table alone. Only the bench's scenarios can show the arithmetic result against a convolution model, across coefficient sets with many, few and no zero differences and with extreme operands. The same holds for the exact latency before and after the store fills, which the bench measures from the accepting edge.

// File: rtl/fir_dc_pkg.sv
`timescale 1ns/1ps
package fir_dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_OUT  = 2'd2
  } dc_state_e;
endpackage

// File: rtl/dc_coef_table.sv
`timescale 1ns/1ps
// Holds the raw first coefficient and the first-order differences.
module dc_coef_table #(
  parameter int NTAP = 4,
  parameter int CW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_first,
  input  logic signed [CW-1:0] wr_coef,
  output logic signed [CW-1:0] c0_o,
  output logic signed [CW:0]   diff_o [NTAP],
  output logic [NTAP-1:0]      nz_o
);
  localparam int IW = $clog2(NTAP + 1);

  logic [IW-1:0]        wr_idx;
  logic [IW-1:0]        idx_eff;
  logic signed [CW-1:0] prev_c;
  logic signed [CW-1:0] c0_r;
  logic signed [CW:0]   diff_r [NTAP];
  logic signed [CW:0]   step;

  assign idx_eff = wr_first ? '0 : wr_idx;
  assign step    = (CW+1)'(wr_coef) - (CW+1)'(prev_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      prev_c <= '0;
      c0_r   <= '0;
      for (int k = 0; k < NTAP; k++) diff_r[k] <= '0;
    end else if (wr_en && (idx_eff < IW'(NTAP))) begin
      if (idx_eff == '0) c0_r <= wr_coef;
      for (int k = 1; k < NTAP; k++) begin
        if (idx_eff == IW'(k)) diff_r[k] <= step;
      end
      prev_c <= wr_coef;
      wr_idx <= idx_eff + IW'(1);
    end
  end

  assign c0_o = c0_r;

  genvar g;
  generate
    for (g = 0; g < NTAP; g++) begin : g_tap
      assign diff_o[g] = diff_r[g];
      if (g == 0) begin : g_head
        assign nz_o[g] = 1'b0;
      end else begin : g_rest
        assign nz_o[g] = (diff_r[g] != '0);
      end
    end
  endgenerate

  AST_SURPLUS_BEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_first && (wr_idx == IW'(NTAP))) |=> ($stable(c0_r) && $stable(diff_r[NTAP-1]))); // R2
endmodule

// File: rtl/dc_sample_line.sv
`timescale 1ns/1ps
// Sample history: x_o[k] is the sample k steps back.
module dc_sample_line #(
  parameter int NTAP = 4,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 shift,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] x_o [NTAP]
);
  logic signed [DW-1:0] line [NTAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++) line[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < NTAP; k++) line[k] <= '0;
    end else if (shift) begin
      line[0] <= din;
      for (int k = 1; k < NTAP; k++) line[k] <= line[k-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NTAP; g++) begin : g_out
      assign x_o[g] = line[g];
    end
  endgenerate

  AST_LINE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (line[1] == $past(line[0]) && line[0] == $past(din))); // R1
endmodule

// File: rtl/dc_term_store.sv
`timescale 1ns/1ps
// Per-tap product terms kept between outputs.
module dc_term_store #(
  parameter int NTAP = 4,
  parameter int TW   = 16,
  parameter int AW   = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    shift,
  input  logic                    wr_en,
  input  logic [$clog2(NTAP)-1:0] wr_idx,
  input  logic signed [TW-1:0]    wr_val,
  output logic signed [TW-1:0]    p_o [NTAP],
  output logic signed [AW-1:0]    carry_sum_o
);
  logic signed [TW-1:0] term [NTAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++) term[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < NTAP; k++) term[k] <= '0;
    end else if (shift) begin
      term[0] <= '0;
      for (int k = 1; k < NTAP; k++) term[k] <= term[k-1];
    end else if (wr_en) begin
      term[wr_idx] <= wr_val;
    end
  end

  // Sum of the terms that move up one tap on the next shift.
  always_comb begin
    carry_sum_o = '0;
    for (int k = 0; k < NTAP - 1; k++) carry_sum_o = carry_sum_o + AW'(term[k]);
  end

  genvar g;
  generate
    for (g = 0; g < NTAP; g++) begin : g_out
      assign p_o[g] = term[g];
    end
  endgenerate

  AST_STORE_HEAD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (term[0] == '0 && term[1] == $past(term[0]))); // R1
endmodule

// File: rtl/fir_diffcoef.sv
`timescale 1ns/1ps
module fir_diffcoef
  import fir_dc_pkg::*;
#(
  parameter int NTAP = 4,
  parameter int DW   = 8,
  parameter int CW   = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cfg_valid,
  output logic                                       cfg_ready,
  input  logic                                       cfg_first,
  input  logic signed [CW-1:0]                       cfg_coef,
  input  logic                                       in_valid,
  output logic                                       in_ready,
  input  logic signed [DW-1:0]                       in_data,
  output logic                                       out_valid,
  input  logic                                       out_ready,
  output logic signed [CW+DW+$clog2(NTAP)-1:0]       out_data
);
  localparam int DFW = CW + 1;
  localparam int TW  = CW + DW;
  localparam int AW  = TW + $clog2(NTAP);
  localparam int KW  = $clog2(NTAP);
  localparam int FW  = $clog2(NTAP + 1);

  dc_state_e            st;
  logic [KW-1:0]        tap;
  logic                 warm;
  logic [FW-1:0]        fill;
  logic signed [CW-1:0] crun;
  logic signed [AW-1:0] acc;
  logic [FW-1:0]        calc_cyc;

  logic                 cfg_fire, acc_fire, load_clr, direct;
  logic signed [CW-1:0] c0;
  logic signed [DFW-1:0] diff [NTAP];
  logic [NTAP-1:0]      nz;
  logic signed [DW-1:0] x [NTAP];
  logic signed [TW-1:0] p [NTAP];
  logic signed [AW-1:0] carry_sum;
  logic signed [DFW-1:0] coef_sel;
  logic signed [DW-1:0]  x_sel;
  logic signed [TW:0]    prod;
  logic signed [TW:0]    base;
  logic signed [TW:0]    new_wide;
  logic signed [TW-1:0]  new_term;
  logic [KW-1:0]         nxt;
  logic                  has_nxt;
  logic signed [DFW-1:0] crun_wide;
  logic                  in_calc;

  assign cfg_ready = (st == ST_IDLE);
  assign in_ready  = (st == ST_IDLE) && !cfg_valid;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign acc_fire  = in_valid && in_ready;
  assign load_clr  = cfg_fire && cfg_first;
  assign in_calc   = (st == ST_CALC);
  assign out_valid = (st == ST_OUT);
  assign out_data  = acc;

  dc_coef_table #(.NTAP(NTAP), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_fire), .wr_first(cfg_first), .wr_coef(cfg_coef),
    .c0_o(c0), .diff_o(diff), .nz_o(nz)
  );

  dc_sample_line #(.NTAP(NTAP), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n),
    .clr(load_clr), .shift(acc_fire), .din(in_data), .x_o(x)
  );

  dc_term_store #(.NTAP(NTAP), .TW(TW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clr(load_clr), .shift(acc_fire),
    .wr_en(in_calc), .wr_idx(tap), .wr_val(new_term),
    .p_o(p), .carry_sum_o(carry_sum)
  );

  // One shared multiplier: running coefficient, raw c0, or a difference.
  assign direct   = warm || (tap == '0);
  assign coef_sel = warm ? DFW'(crun) : ((tap == '0) ? DFW'(c0) : diff[tap]);
  assign x_sel    = x[tap];
  assign prod     = coef_sel * x_sel;
  assign base     = direct ? '0 : (TW+1)'(p[tap]);
  assign new_wide = base + prod;
  assign new_term = new_wide[TW-1:0];
  assign crun_wide = DFW'(crun) + diff[nxt];

  // Next tap to visit: every tap when warming up, else only nonzero differences.
  always_comb begin
    nxt     = '0;
    has_nxt = 1'b0;
    for (int j = 1; j < NTAP; j++) begin
      if (!has_nxt && (j > int'(tap)) && (warm || nz[j])) begin
        nxt     = KW'(j);
        has_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      tap  <= '0;
      warm <= 1'b1;
      fill <= '0;
      crun <= '0;
      acc  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (load_clr) begin
            fill <= '0;
          end else if (acc_fire) begin
            warm <= (fill < FW'(NTAP));
            acc  <= (fill < FW'(NTAP)) ? '0 : carry_sum;
            crun <= c0;
            tap  <= '0;
            st   <= ST_CALC;
          end
        end
        ST_CALC: begin
          acc  <= acc + AW'(prod);
          crun <= crun_wide[CW-1:0];
          if (has_nxt) begin
            tap <= nxt;
          end else begin
            st <= ST_OUT;
            if (fill < FW'(NTAP)) fill <= fill + FW'(1);
          end
        end
        ST_OUT: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Cycle count of the current walk, used only by the checks below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        calc_cyc <= '0;
    else if (acc_fire) calc_cyc <= '0;
    else if (in_calc)  calc_cyc <= calc_cyc + FW'(1);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R6
  AST_SKIP_ZERO_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_calc && !warm && (tap != '0)) |-> nz[tap]); // R5
  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_calc |-> (calc_cyc < FW'(NTAP))); // R4
  AST_WARM_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_calc && warm) |-> (FW'(tap) == calc_cyc)); // R3
  AST_CFG_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fire |=> (!out_valid && !in_calc)); // R9
endmodule

// File: tb/sim_fir_diffcoef.sv
`timescale 1ns/1ps
module sim_fir_diffcoef;
  localparam int NT = 4;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int AW = CW + DW + $clog2(NT);

  localparam int SAMP [12] = '{17, -128, 127, -3, 0, 64, -64, 5, -128, -128, 99, -1};
  localparam int CSET [4][4] = '{
    '{3, -5, 7, 2},
    '{5, 5, -2, -2},
    '{9, 9, 9, 9},
    '{-128, 127, -128, 127}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0, cfg_first = 1'b0;
  logic signed [CW-1:0] cfg_coef = '0;
  logic cfg_ready;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [AW-1:0] out_data;

  int tests = 0, fails = 0;
  int coefs [4];
  int hist [4];
  int nout = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fir_diffcoef #(.NTAP(NT), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_first(cfg_first), .cfg_coef(cfg_coef),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int c [4], input bit extra, input int xval);
    for (int i = 0; i < (extra ? NT + 1 : NT); i++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_first = (i == 0);
      cfg_coef  = CW'((i < NT) ? c[i] : xval);
      @(posedge clk); #1;
    end
    cfg_valid = 1'b0;
    cfg_first = 1'b0;
    for (int k = 0; k < NT; k++) begin coefs[k] = c[k]; hist[k] = 0; end
    nout = 0;
  endtask

  task automatic send(input int xv, input int hold, input string rq_out, input string rq_lat);
    int expv, lat, nnz, explat;
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = xv;
    expv = 0;
    for (int k = 0; k < NT; k++) expv += coefs[k] * hist[k];
    nnz = 0;
    for (int k = 1; k < NT; k++) if (coefs[k] != coefs[k-1]) nnz++;
    explat = (nout < NT) ? NT : 1 + nnz;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(xv);
    @(posedge clk); #1;
    in_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!out_valid && lat < 40);
    chk(lat == explat, rq_lat, lat, explat);
    chk(longint'(out_data) == longint'(expv), rq_out, longint'(out_data), expv);
    for (int i = 0; i < hold; i++) begin
      chk(out_valid && !in_ready && longint'(out_data) == longint'(expv), "R6",
          longint'(out_data), expv);
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    nout++;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int zc [4];
    int cs [4];
    for (int k = 0; k < NT; k++) begin zc[k] = 0; coefs[k] = 0; hist[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    chk(!out_valid, "R7", out_valid, 0);
    chk(in_ready, "R7", in_ready, 1);
    chk(cfg_ready, "R7", cfg_ready, 1);
    send(50, 0, "R7", "R3");
    send(-7, 0, "R7", "R3");

    // R9: cfg beat blocks sample intake in the same cycle
    @(negedge clk);
    cfg_valid = 1'b1; cfg_first = 1'b1; cfg_coef = '0;
    in_valid = 1'b1;
    #0.5;
    chk(!in_ready, "R9", in_ready, 0);
    cfg_valid = 1'b0; cfg_first = 1'b0; in_valid = 1'b0;

    // Table walk: each coefficient set over every sample
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < NT; k++) cs[k] = CSET[s][k];
      load(cs, 1'b0, 0);
      for (int i = 0; i < 12; i++)
        send(SAMP[i], 0, (s == 3) ? "R8" : "R1",
             (i < NT) ? "R3" : ((s == 2) ? "R5" : "R4"));
    end

    // R2: surplus beat ignored, load restarts history
    for (int k = 0; k < NT; k++) cs[k] = CSET[1][k];
    load(cs, 1'b1, 100);
    for (int i = 0; i < 6; i++) send(SAMP[11 - i], 0, "R2", (i < NT) ? "R3" : "R4");

    // R6: back-pressure hold
    send(77, 3, "R1", "R4");
    send(-128, 2, "R1", "R4");

    // R5: all-equal set, steady state single cycle
    for (int k = 0; k < NT; k++) cs[k] = CSET[2][k];
    load(cs, 1'b0, 0);
    for (int i = 0; i < 7; i++) send(-128, 0, "R5", (i < NT) ? "R3" : "R5");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule